// File: doc/BRIEF.md
# Programmable Binary Interval Timer

This block is a 24-stage binary counter that advances on the falling edges of an external tick input. The tick is sampled by the system clock, so the whole block runs in one clock domain. A single output, `tap_out`, follows one chosen stage of the counter. Two inputs pick that stage: a 4-bit select and a bypass bit that moves the choice past the first eight stages. Left running, the block divides the tick by a power of two. With the preset and hold controls it becomes a one-shot interval timer with a known start edge.

The control sequencer has three states:

- **HALT**: counting is stopped. The block enters it on clear, or from RUN when hold rises.
- **ARMED**: preset has loaded the counter, and the block waits for hold to drop. Preset forces this state from any state, asynchronously.
- **RUN**: every detected tick falling edge advances the counter. HALT and ARMED both move to RUN when the synchronized hold goes low.

`tap_out` has no defined level before the first clear or preset, so a user must apply one of them before relying on it.

Top module: `bin_interval_timer`

## Requirements
- R1: While `clear` is high, every stage is zero and `tap_out` is 0 at once, whatever the level of `preset`. After `clear` is released, counting starts from zero.
- R2: While `preset` is high and `clear` is low, every stage is one and `tap_out` is 1 at once. `tap_out` stays 1 after `preset` is released, until a counted tick edge.
- R3: The tapped stage index is k = `sel` + 8 when `bypass` is 1, and k = `sel` when `bypass` is 0. This gives stages 0..15 with bypass low and 8..23 with bypass high. While running from a clear, `tap_out` equals bit k of the number of counted tick falling edges. This is a square wave with a period of 2^(k+1) tick cycles.
- R4: While `hold` is high, tick edges are ignored and both the count and `tap_out` keep their values. When `hold` goes low, counting resumes from the held count.
- R5: After a preset with `hold` high, the first tick falling edge once `hold` is low drives `tap_out` low. `tap_out` returns high on falling edge number 2^k + 1 counted from that release.
- R6: A change of `sel` or `bypass` shows on `tap_out` within two system clock cycles and does not change the count.
- R7: The counter wraps from all ones to all zeros on a counted edge.
- R8: The effect of a tick falling edge reaches `tap_out` no later than four system clock cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every other input |
| clear | input | 1 | Asynchronous clear of counter, output and sequencer, active high |
| preset | input | 1 | Asynchronous load of all ones, active high |
| hold | input | 1 | Counting inhibit, active high |
| tick | input | 1 | External count clock; counting happens on its falling edges |
| sel | input | 4 | Tap select within the current window of 16 stages |
| bypass | input | 1 | Moves the tap window up by eight stages |
| tap_out | output | 1 | Registered value of the selected stage |

## Verification
The case hardest to reach from the ports is a long one-shot interval on a high tap. Reaching it means loading the counter to all ones, holding it across tick activity, and then releasing it. The count must first wrap to zero and then climb to 2^k. The stimulus presets with hold high and drives tick edges that must be ignored. It then drops hold and counts out 2^k + 2 falling edges for taps up to stage 8, sampling after every edge exactly at the four-cycle latency bound. Free-running sweeps check every edge against bit k of an edge counter kept in the bench.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int unsigned SEL_W_DEF = 4;
    localparam int unsigned SKIP_DEF  = 8;
    localparam int unsigned SYNC_DEF  = 2;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } ivt_state_e;
endpackage

// File: rtl/ivt_edge_sync.sv
module ivt_edge_sync #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic clear,
    input  logic tick_in,
    input  logic hold_in,
    output logic tick_fall,
    output logic hold_sync
);
    logic [DEPTH-1:0] tick_q;
    logic [DEPTH-1:0] hold_q;
    logic             tick_last;

    // Synchronizer chains; hold resets to the inhibited level.
    always_ff @(posedge clk or posedge clear) begin
        if (clear) begin
            tick_q    <= '0;
            hold_q    <= '1;
            tick_last <= 1'b0;
        end else begin
            for (int i = DEPTH - 1; i > 0; i--) begin
                tick_q[i] <= tick_q[i-1];
                hold_q[i] <= hold_q[i-1];
            end
            tick_q[0] <= tick_in;
            hold_q[0] <= hold_in;
            tick_last <= tick_q[DEPTH-1];
        end
    end

    assign tick_fall = tick_last & ~tick_q[DEPTH-1];
    assign hold_sync = hold_q[DEPTH-1];
endmodule

// File: rtl/ivt_ctrl_fsm.sv
module ivt_ctrl_fsm
    import ivt_pkg::*;
(
    input  logic clk,
    input  logic clear,
    input  logic preset,
    input  logic hold_sync,
    output logic run_en
);
    ivt_state_e state_q;
    ivt_state_e state_d;

    // State register: clear wins over preset.
    always_ff @(posedge clk or posedge clear or posedge preset) begin
        if (clear) begin
            state_q <= ST_HALT;
        end else if (preset) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  state_d = hold_sync ? ST_HALT  : ST_RUN;
            ST_ARMED: state_d = hold_sync ? ST_ARMED : ST_RUN;
            ST_RUN:   state_d = hold_sync ? ST_HALT  : ST_RUN;
            default:  state_d = ST_HALT;
        endcase
    end

    // Output decode
    always_comb begin
        run_en = 1'b0;
        unique case (state_q)
            ST_HALT:  run_en = 1'b0;
            ST_ARMED: run_en = 1'b0;
            ST_RUN:   run_en = 1'b1;
            default:  run_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/ivt_stage_chain.sv
module ivt_stage_chain #(
    parameter int unsigned STAGES = 24
) (
    input  logic              clk,
    input  logic              clear,
    input  logic              preset,
    input  logic              advance,
    output logic [STAGES-1:0] stage_q
);
    always_ff @(posedge clk or posedge clear or posedge preset) begin
        if (clear) begin
            stage_q <= '0;
        end else if (preset) begin
            stage_q <= '1;
        end else if (advance) begin
            stage_q <= stage_q + 1'b1;
        end
    end
endmodule

// File: rtl/ivt_tap_sel.sv
module ivt_tap_sel #(
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned SKIP   = 8,
    parameter int unsigned STAGES = 24
) (
    input  logic              clk,
    input  logic              clear,
    input  logic              preset,
    input  logic [STAGES-1:0] stage_q,
    input  logic [SEL_W-1:0]  sel,
    input  logic              bypass,
    output logic              tap_out
);
    localparam int unsigned IDX_W = $clog2(STAGES);

    logic [IDX_W-1:0] tap_idx;

    always_comb begin
        tap_idx = IDX_W'(sel) + (bypass ? IDX_W'(SKIP) : '0);
    end

    always_ff @(posedge clk or posedge clear or posedge preset) begin
        if (clear) begin
            tap_out <= 1'b0;
        end else if (preset) begin
            tap_out <= 1'b1;
        end else begin
            tap_out <= stage_q[tap_idx];
        end
    end
endmodule

// File: rtl/bin_interval_timer.sv
module bin_interval_timer
    import ivt_pkg::*;
#(
    parameter int unsigned SEL_W = SEL_W_DEF,
    parameter int unsigned SKIP  = SKIP_DEF,
    parameter int unsigned SYNC  = SYNC_DEF
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             preset,
    input  logic             hold,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    input  logic             bypass,
    output logic             tap_out
);
    localparam int unsigned STAGES = SKIP + (1 << SEL_W);

    logic              tick_fall;
    logic              hold_sync;
    logic              run_en;
    logic              advance;
    logic [STAGES-1:0] stage_q;

    ivt_edge_sync #(.DEPTH(SYNC)) u_sync (
        .clk       (clk),
        .clear     (clear),
        .tick_in   (tick),
        .hold_in   (hold),
        .tick_fall (tick_fall),
        .hold_sync (hold_sync)
    );

    ivt_ctrl_fsm u_fsm (
        .clk       (clk),
        .clear     (clear),
        .preset    (preset),
        .hold_sync (hold_sync),
        .run_en    (run_en)
    );

    assign advance = run_en & tick_fall;

    ivt_stage_chain #(.STAGES(STAGES)) u_chain (
        .clk     (clk),
        .clear   (clear),
        .preset  (preset),
        .advance (advance),
        .stage_q (stage_q)
    );

    ivt_tap_sel #(.SEL_W(SEL_W), .SKIP(SKIP), .STAGES(STAGES)) u_tap (
        .clk     (clk),
        .clear   (clear),
        .preset  (preset),
        .stage_q (stage_q),
        .sel     (sel),
        .bypass  (bypass),
        .tap_out (tap_out)
    );
endmodule

// File: rtl/bin_interval_timer_chk.sv
module bin_interval_timer_chk #(
    parameter int unsigned STAGES = 24
) (
    input logic              clk,
    input logic              clear,
    input logic              preset,
    input logic              tap_out,
    input logic [STAGES-1:0] stage_q,
    input logic              tick_fall,
    input logic              run_en
);
    always @(posedge clk) begin
        if (clear) begin
            // R1
            clear_low_chk: assert (tap_out == 1'b0 && stage_q == '0);
        end else if (preset) begin
            // R2
            preset_high_chk: assert (tap_out == 1'b1 && stage_q == '1);
        end
    end

    // R4
    halt_freeze_chk: assert property (@(posedge clk) disable iff (clear || preset)
        !run_en |=> $stable(stage_q));

    // R7
    step_one_chk: assert property (@(posedge clk) disable iff (clear || preset)
        !$stable(stage_q) |-> stage_q == $past(stage_q) + 1'b1);

    // R3
    fall_only_chk: assert property (@(posedge clk) disable iff (clear || preset)
        !$stable(stage_q) |-> $past(tick_fall) && $past(run_en));
endmodule

bind bin_interval_timer bin_interval_timer_chk #(.STAGES(STAGES)) u_chk (
    .clk       (clk),
    .clear     (clear),
    .preset    (preset),
    .tap_out   (tap_out),
    .stage_q   (stage_q),
    .tick_fall (tick_fall),
    .run_en    (run_en)
);

// File: tb/bin_interval_timer_tb.sv
module bin_interval_timer_tb;
    logic       clk = 1'b0;
    logic       clear;
    logic       preset;
    logic       hold;
    logic       tick;
    logic [3:0] sel;
    logic       bypass;
    logic       tap_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bin_interval_timer u_dut (
        .clk     (clk),
        .clear   (clear),
        .preset  (preset),
        .hold    (hold),
        .tick    (tick),
        .sel     (sel),
        .bypass  (bypass),
        .tap_out (tap_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Falling edge, sample exactly four system cycles later (R8 bound).
    task automatic fall_sample(input string req, input logic exp);
        tick = 1'b0;
        repeat (4) @(negedge clk);
        chk(req, tap_out, exp);
        tick = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse();
        tick = 1'b0;
        repeat (4) @(negedge clk);
        tick = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        clear = 1'b1; preset = 1'b0; hold = 1'b1; tick = 1'b1;
        sel = '0; bypass = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", tap_out, 1'b0);
        clear = 1'b0;

        // R3, R8: free-running sweep, per edge
        for (int b = 0; b < 2; b++) begin
            for (int s = 0; s < 6; s++) begin
                if (b == 1 && s > 0) break;
                begin
                    int k;
                    k = s + 8 * b;
                    sel = 4'(s); bypass = b[0]; hold = 1'b1;
                    do_clear();
                    hold = 1'b0;
                    repeat (4) @(negedge clk);
                    for (int m = 1; m <= (1 << (k + 2)); m++)
                        fall_sample("R3,R8", 1'((m >> k) & 1));
                end
            end
        end

        // R6: tap change while held at count 37
        sel = '0; bypass = 1'b0; hold = 1'b1;
        do_clear();
        hold = 1'b0;
        repeat (4) @(negedge clk);
        repeat (37) pulse();
        hold = 1'b1;
        repeat (4) @(negedge clk);
        for (int s = 0; s < 6; s++) begin
            sel = 4'(s);
            repeat (2) @(negedge clk);
            chk("R6", tap_out, 1'((37 >> s) & 1));
        end
        sel = '0; bypass = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6", tap_out, 1'b0);
        bypass = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6", tap_out, 1'b1);

        // R4: edges ignored while held, then resume from 37
        for (int i = 0; i < 10; i++) fall_sample("R4", 1'b1);
        sel = 4'd1;
        hold = 1'b0;
        repeat (4) @(negedge clk);
        fall_sample("R4", 1'b1);   // 38
        fall_sample("R4", 1'b1);   // 39
        fall_sample("R4", 1'b0);   // 40

        // R2, R5, R7: one-shot intervals
        for (int c = 0; c < 4; c++) begin
            int k;
            k = (c == 0) ? 0 : (c == 1) ? 2 : (c == 2) ? 5 : 8;
            bypass = (k >= 8);
            sel = 4'(k - (bypass ? 8 : 0));
            hold = 1'b1;
            do_clear();
            @(negedge clk);
            preset = 1'b1;
            #1;
            chk("R2", tap_out, 1'b1);
            @(negedge clk);
            @(negedge clk);
            preset = 1'b0;
            @(negedge clk);
            chk("R2", tap_out, 1'b1);
            for (int i = 0; i < 3; i++) fall_sample("R4", 1'b1);
            hold = 1'b0;
            repeat (4) @(negedge clk);
            for (int j = 1; j <= (1 << k) + 2; j++) begin
                if (j == 1) fall_sample("R7", 1'b0);
                else        fall_sample("R5", 1'(((j - 1) >> k) & 1));
            end
        end

        // R1: clear overrides preset, count restarts at zero
        sel = '0; bypass = 1'b0; hold = 1'b1;
        @(negedge clk);
        clear = 1'b1;
        preset = 1'b1;
        #1;
        chk("R1", tap_out, 1'b0);
        @(negedge clk);
        preset = 1'b0;
        @(negedge clk);
        clear = 1'b0;
        @(negedge clk);
        chk("R1", tap_out, 1'b0);
        hold = 1'b0;
        repeat (4) @(negedge clk);
        fall_sample("R1", 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule